// File: doc/BRIEF.md
# Multi-Layer Up/Down Route Filter

This unit sits inside each router of a network whose topology is only known after assembly, for example a stack of dies where some layers may lack horizontal links. Each virtual-channel layer carries its own spanning tree. Every output port is marked, per layer, as a hop toward that layer's root ("up") or away from it ("down"). A packet may climb any number of up hops and then descend any number of down hops, but once it has taken a down hop it may never go up again in the same layer. A packet may also drop from its layer to any lower-numbered layer, which restarts the up/down rule against the new layer's tree. It can never move to a higher-numbered layer.

The header of each packet carries its current layer and a one-bit descent flag. The flag is clear at injection and becomes set after the first down hop. For each request, the filter reads a per-port table. Each table entry holds a presence bit, an up bit for each layer, and a "minimal toward the destination" bit for each layer. From these the filter works out the legal port and layer pairs and picks one. One cycle later it returns the chosen port, the new layer and the new descent flag, or it raises a no-route indication. The table is filled through a plain address/data/write-enable port by whatever logic computes the trees.

Top module: `ud_route_filter`

## Requirements
- R1: After reset, all response outputs are 0 and every table entry is absent, so the first request on an unwritten table produces a no-route response.
- R2: A table write takes effect from the next cycle. A request presented in the same cycle as a write is decided with the old entry. Entry encoding: bit 0 present, bit 1+l up in layer l, bit 1+NUM_LAYERS+l minimal in layer l.
- R3: When the request's descent flag is 1, no port whose up bit is set in the request's current layer is chosen in that layer.
- R4: A candidate in a layer is legal only if it is present and minimal in that layer. When the descent flag is 0, both up and down ports of the current layer are legal.
- R5: If any legal port exists in the current layer, it is chosen, and among the legal ports the lowest index wins.
- R6: If the current layer has no legal port, the filter uses the highest-numbered lower layer that has one, picking the lowest index there. Higher-numbered layers are never used, and the returned layer never exceeds the request's layer.
- R7: The returned descent flag is (old flag OR the chosen port is a down hop) when the layer is unchanged. After a layer change it is 1 exactly when the chosen port is a down hop in the new layer.
- R8: With no legal candidate in any permitted layer, the no-route output is 1 and the forward output is 0. The two are never both 1.
- R9: Each response appears exactly one cycle after its request. Without a request, both indications are 0 and the port, layer and flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | PORT_W | Port whose entry is written |
| tbl_wr_data | input | 1+2*NUM_LAYERS | Entry value (present, up per layer, minimal per layer) |
| req_valid | input | 1 | Route request present |
| req_layer | input | LAYER_W | Packet's current virtual-channel layer |
| req_phase | input | 1 | Descent flag from the header |
| rsp_fwd | output | 1 | A legal route was found |
| rsp_noroute | output | 1 | No legal route exists |
| rsp_port | output | PORT_W | Chosen output port |
| rsp_layer | output | LAYER_W | Layer the packet leaves on |
| rsp_phase | output | 1 | Updated descent flag for the header |

## Verification
The bench builds the filter with eight ports and two layers. With that build, the highest port index can be chosen, and the single downward fallback from layer 1 to layer 0 can be exercised with and without a descent flag. Directed sequences cover the blocking of up ports after descent, the restart of the flag on a layer change, writes that collide with requests, and empty or non-minimal tables. A long random phase follows, in which table rewrites are mixed with requests. A behavioural reference model checks every response.

// File: rtl/ud_route_pkg.sv
// Shared helpers for the up/down route filter.
// Assumes entries are packed as {minimal[L-1:0], up[L-1:0], present}.
package ud_route_pkg;

    // Width of an index over n items, never less than one bit.
    function automatic int idx_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Width of one table entry for a given number of layers.
    function automatic int entry_w(input int layers);
        return 1 + 2 * layers;
    endfunction

    // Bit position of the up flag of layer l.
    function automatic int up_pos(input int l);
        return 1 + l;
    endfunction

    // Bit position of the minimal flag of layer l.
    function automatic int min_pos(input int layers, input int l);
        return 1 + layers + l;
    endfunction

endpackage

// File: rtl/ud_route_table.sv
// Per-port direction/minimality table.
// Registered storage, written one entry per cycle. The contents are exposed
// as per-layer vectors, so that readers see the value before any write in
// the same cycle. Assumes write addresses at or above NUM_PORTS are dropped.
module ud_route_table
    import ud_route_pkg::*;
#(
    parameter int NUM_PORTS  = 8,
    parameter int NUM_LAYERS = 2,
    localparam int PORT_W    = idx_w(NUM_PORTS),
    localparam int ENTRY_W   = entry_w(NUM_LAYERS)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [PORT_W-1:0]                     wr_addr,
    input  logic [ENTRY_W-1:0]                    wr_data,
    output logic [NUM_PORTS-1:0]                  present,
    output logic [NUM_LAYERS-1:0][NUM_PORTS-1:0]  up,
    output logic [NUM_LAYERS-1:0][NUM_PORTS-1:0]  minimal
);

    logic [ENTRY_W-1:0] tbl_q [NUM_PORTS];

    // Store entries; reset empties the table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                tbl_q[p] <= '0;
            end
        end else if (wr_en && (int'(wr_addr) < NUM_PORTS)) begin
            tbl_q[wr_addr] <= wr_data;
        end
    end

    // Split entries into per-layer vectors.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign present[p] = tbl_q[p][0];
        for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
            assign up[l][p]      = tbl_q[p][up_pos(l)];
            assign minimal[l][p] = tbl_q[p][min_pos(NUM_LAYERS, l)];
        end
    end

endmodule

// File: rtl/ud_layer_legal.sv
// Legal-candidate mask for one layer.
// A port is legal when the layer is permitted, the port exists and is
// minimal in this layer, and it is not an up hop while up hops are blocked.
module ud_layer_legal #(
    parameter int NUM_PORTS = 8
) (
    input  logic                 enable,
    input  logic                 block_up,
    input  logic [NUM_PORTS-1:0] present,
    input  logic [NUM_PORTS-1:0] up,
    input  logic [NUM_PORTS-1:0] minimal,
    output logic [NUM_PORTS-1:0] legal
);

    // Combine presence, minimality and the turn rule.
    always_comb begin
        legal = present & minimal & ~(up & {NUM_PORTS{block_up}});
        if (!enable) begin
            legal = '0;
        end
    end

endmodule

// File: rtl/ud_port_pick.sv
// Fixed-priority picker: lowest set index wins.
// found is 0 and idx is 0 when the mask is empty.
module ud_port_pick
    import ud_route_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    localparam int PORT_W   = idx_w(NUM_PORTS)
) (
    input  logic [NUM_PORTS-1:0] mask,
    output logic                 found,
    output logic [PORT_W-1:0]    idx
);

    // Scan from the top so that the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = PORT_W'(i);
            end
        end
    end

endmodule

// File: rtl/ud_route_filter.sv
// Multi-layer up/down route filter (top).
// Applies the up-then-down rule in each virtual-channel layer, lets packets
// fall only to lower layers (restarting the descent flag), and registers the
// decision with one cycle of latency. Assumes the table reflects each
// layer's spanning tree and the packet's destination.
module ud_route_filter
    import ud_route_pkg::*;
#(
    parameter int NUM_PORTS  = 8,
    parameter int NUM_LAYERS = 2,
    localparam int PORT_W    = idx_w(NUM_PORTS),
    localparam int LAYER_W   = idx_w(NUM_LAYERS),
    localparam int ENTRY_W   = entry_w(NUM_LAYERS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_wr_en,
    input  logic [PORT_W-1:0]  tbl_wr_addr,
    input  logic [ENTRY_W-1:0] tbl_wr_data,
    input  logic               req_valid,
    input  logic [LAYER_W-1:0] req_layer,
    input  logic               req_phase,
    output logic               rsp_fwd,
    output logic               rsp_noroute,
    output logic [PORT_W-1:0]  rsp_port,
    output logic [LAYER_W-1:0] rsp_layer,
    output logic               rsp_phase
);

    logic [NUM_PORTS-1:0]                  tbl_present;
    logic [NUM_LAYERS-1:0][NUM_PORTS-1:0]  tbl_up;
    logic [NUM_LAYERS-1:0][NUM_PORTS-1:0]  tbl_min;
    logic [NUM_LAYERS-1:0][NUM_PORTS-1:0]  legal;
    logic [NUM_LAYERS-1:0]                 lay_found;
    logic [NUM_LAYERS-1:0][PORT_W-1:0]     lay_idx;
    logic                                  layer_ok;
    logic                                  sel_found;
    logic [LAYER_W-1:0]                    sel_layer;
    logic [PORT_W-1:0]                     sel_port;
    logic                                  sel_up;
    logic                                  sel_phase;

    ud_route_table #(
        .NUM_PORTS  (NUM_PORTS),
        .NUM_LAYERS (NUM_LAYERS)
    ) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .present (tbl_present),
        .up      (tbl_up),
        .minimal (tbl_min)
    );

    // Request layer must name an existing layer.
    assign layer_ok = ({1'b0, req_layer} < (LAYER_W + 1)'(NUM_LAYERS));

    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
        logic en_l;
        logic blk_l;
        assign en_l  = layer_ok && ((LAYER_W + 1)'(l) <= {1'b0, req_layer});
        assign blk_l = ((LAYER_W + 1)'(l) == {1'b0, req_layer}) && req_phase;

        ud_layer_legal #(
            .NUM_PORTS (NUM_PORTS)
        ) legal_i (
            .enable   (en_l),
            .block_up (blk_l),
            .present  (tbl_present),
            .up       (tbl_up[l]),
            .minimal  (tbl_min[l]),
            .legal    (legal[l])
        );

        ud_port_pick #(
            .NUM_PORTS (NUM_PORTS)
        ) pick_i (
            .mask  (legal[l]),
            .found (lay_found[l]),
            .idx   (lay_idx[l])
        );
    end

    // Choose the layer: the current one first, else the highest lower one.
    always_comb begin
        sel_found = 1'b0;
        sel_layer = '0;
        sel_port  = '0;
        for (int l = 0; l < NUM_LAYERS; l++) begin
            if (lay_found[l] && ((LAYER_W + 1)'(l) < {1'b0, req_layer})) begin
                sel_found = 1'b1;
                sel_layer = LAYER_W'(l);
                sel_port  = lay_idx[l];
            end
        end
        for (int l = 0; l < NUM_LAYERS; l++) begin
            if (lay_found[l] && ((LAYER_W + 1)'(l) == {1'b0, req_layer})) begin
                sel_found = 1'b1;
                sel_layer = LAYER_W'(l);
                sel_port  = lay_idx[l];
            end
        end
    end

    // Work out the new descent flag from the chosen hop.
    always_comb begin
        sel_up = 1'b0;
        for (int l = 0; l < NUM_LAYERS; l++) begin
            if (LAYER_W'(l) == sel_layer) begin
                sel_up = tbl_up[l][sel_port];
            end
        end
        sel_phase = ((sel_layer == req_layer) && req_phase) || !sel_up;
    end

    // Register the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_fwd     <= 1'b0;
            rsp_noroute <= 1'b0;
            rsp_port    <= '0;
            rsp_layer   <= '0;
            rsp_phase   <= 1'b0;
        end else begin
            rsp_fwd     <= req_valid && sel_found;
            rsp_noroute <= req_valid && !sel_found;
            rsp_port    <= (req_valid && sel_found) ? sel_port : '0;
            rsp_layer   <= (req_valid && sel_found) ? sel_layer : '0;
            rsp_phase   <= req_valid && sel_found && sel_phase;
        end
    end

endmodule

// File: rtl/ud_route_filter_chk.sv
// Property checker for the route filter, bound to every instance.
// Observes the ports plus the table's up vectors.
module ud_route_filter_chk
    import ud_route_pkg::*;
#(
    parameter int NUM_PORTS  = 8,
    parameter int NUM_LAYERS = 2,
    localparam int PORT_W    = idx_w(NUM_PORTS),
    localparam int LAYER_W   = idx_w(NUM_LAYERS)
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 req_valid,
    input logic [LAYER_W-1:0]                   req_layer,
    input logic                                 req_phase,
    input logic                                 rsp_fwd,
    input logic                                 rsp_noroute,
    input logic [PORT_W-1:0]                    rsp_port,
    input logic [LAYER_W-1:0]                   rsp_layer,
    input logic                                 rsp_phase,
    input logic [NUM_LAYERS-1:0][NUM_PORTS-1:0] tbl_up
);

    logic [NUM_PORTS-1:0] snap_up;

    // Capture the up vector of the requested layer as seen by the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_up <= '0;
        end else begin
            snap_up <= '0;
            for (int l = 0; l < NUM_LAYERS; l++) begin
                if (LAYER_W'(l) == req_layer) begin
                    snap_up <= tbl_up[l];
                end
            end
        end
    end

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_fwd && rsp_noroute));

    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fwd || rsp_noroute) == $past(req_valid));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_fwd |-> (rsp_port == '0 && rsp_layer == '0 && !rsp_phase));

    assert_down_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fwd |-> (rsp_layer <= $past(req_layer)));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fwd && rsp_layer == $past(req_layer) && $past(req_phase)) |-> rsp_phase);

    assert_no_up_after_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fwd && rsp_layer == $past(req_layer) && $past(req_phase)) |-> !snap_up[rsp_port]);

endmodule

bind ud_route_filter ud_route_filter_chk #(
    .NUM_PORTS  (NUM_PORTS),
    .NUM_LAYERS (NUM_LAYERS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_layer   (req_layer),
    .req_phase   (req_phase),
    .rsp_fwd     (rsp_fwd),
    .rsp_noroute (rsp_noroute),
    .rsp_port    (rsp_port),
    .rsp_layer   (rsp_layer),
    .rsp_phase   (rsp_phase),
    .tbl_up      (tbl_up)
);

// File: tb/ud_route_filter_tb_top.sv
// Self-checking bench: a behavioural reference model is compared with the
// filter's outputs after every clock.
module ud_route_filter_tb_top;

    localparam int P  = 8;
    localparam int L  = 2;
    localparam int PW = 3;
    localparam int LW = 1;
    localparam int EW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tbl_wr_en;
    logic [PW-1:0] tbl_wr_addr;
    logic [EW-1:0] tbl_wr_data;
    logic          req_valid;
    logic [LW-1:0] req_layer;
    logic          req_phase;
    logic          rsp_fwd;
    logic          rsp_noroute;
    logic [PW-1:0] rsp_port;
    logic [LW-1:0] rsp_layer;
    logic          rsp_phase;

    int checks = 0;
    int errors = 0;
    logic [EW-1:0] mtab [P];
    logic e_fwd, e_nr, e_phase;
    int   e_port, e_layer;

    always #2 clk = ~clk;

    ud_route_filter #(.NUM_PORTS(P), .NUM_LAYERS(L)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
        .req_valid(req_valid), .req_layer(req_layer), .req_phase(req_phase),
        .rsp_fwd(rsp_fwd), .rsp_noroute(rsp_noroute), .rsp_port(rsp_port),
        .rsp_layer(rsp_layer), .rsp_phase(rsp_phase)
    );

    // Entry: bit0 present, bit1 up L0, bit2 up L1, bit3 min L0, bit4 min L1.
    function automatic logic [EW-1:0] mk(input bit pr, input bit u0, input bit u1,
                                         input bit m0, input bit m1);
        return {m1, m0, u1, u0, pr};
    endfunction

    // Reference: current layer first, then lower layers from highest down.
    task automatic model(input bit v, input int lay, input bit ph);
        bit found = 0;
        e_fwd = 0; e_nr = 0; e_port = 0; e_layer = 0; e_phase = 0;
        if (!v) return;
        if (lay < L) begin
            for (int l = lay; l >= 0; l--) begin
                for (int p = 0; p < P; p++) begin
                    bit pr = mtab[p][0];
                    bit up = mtab[p][1 + l];
                    bit mn = mtab[p][1 + L + l];
                    if (!found && pr && mn && !(l == lay && ph && up)) begin
                        found   = 1;
                        e_port  = p;
                        e_layer = l;
                        e_phase = ((l == lay) ? ph : 1'b0) | !up;
                    end
                end
            end
        end
        e_fwd = found;
        e_nr  = !found;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (rsp_fwd !== e_fwd || rsp_noroute !== e_nr || int'(rsp_port) != e_port ||
            int'(rsp_layer) != e_layer || rsp_phase !== e_phase) begin
            errors++;
            $display("FAIL %s: got fwd=%0b nr=%0b port=%0d layer=%0d phase=%0b, expected fwd=%0b nr=%0b port=%0d layer=%0d phase=%0b",
                     tag, rsp_fwd, rsp_noroute, rsp_port, rsp_layer, rsp_phase,
                     e_fwd, e_nr, e_port, e_layer, e_phase);
        end
    endtask

    // One clock: drive after a falling edge, check at the next falling edge.
    task automatic cyc(input bit v, input int lay, input bit ph, input bit we,
                       input int wa, input logic [EW-1:0] wd, input string tag);
        req_valid   = v;
        req_layer   = LW'(lay);
        req_phase   = ph;
        tbl_wr_en   = we;
        tbl_wr_addr = PW'(wa);
        tbl_wr_data = wd;
        model(v, lay, ph);
        if (we) mtab[wa] = wd;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr(input int a, input logic [EW-1:0] d);
        cyc(0, 0, 0, 1, a, d, "R9 idle during write");
    endtask

    task automatic clear_all();
        for (int p = 0; p < P; p++) wr(p, '0);
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int p = 0; p < P; p++) mtab[p] = '0;
        rst_n = 0; req_valid = 0; req_layer = 0; req_phase = 0;
        tbl_wr_en = 0; tbl_wr_addr = 0; tbl_wr_data = 0;
        repeat (3) @(negedge clk);
        model(0, 0, 0);
        compare("R1 outputs in reset");
        rst_n = 1;

        // R1: empty table after reset
        cyc(1, 0, 0, 0, 0, '0, "R1 empty table no route");
        cyc(1, 1, 1, 0, 0, '0, "R1 empty table layer1");

        // Port 3: up & minimal in L0; port 5: down & minimal in L0.
        wr(3, mk(1, 1, 0, 1, 0));
        wr(5, mk(1, 0, 0, 1, 0));
        cyc(1, 0, 0, 0, 0, '0, "R4 up allowed before descent");
        cyc(1, 0, 1, 0, 0, '0, "R3 up blocked after descent");
        cyc(0, 0, 0, 0, 0, '0, "R9 no request");

        // Port 1: down & minimal in L1 -> current layer preferred.
        wr(1, mk(1, 0, 0, 0, 1));
        cyc(1, 1, 1, 0, 0, '0, "R5 current layer preferred");
        cyc(1, 1, 0, 0, 0, '0, "R7 down hop sets flag");

        // Port 1 becomes up in L1: blocked after descent, fall to L0.
        wr(1, mk(1, 0, 1, 0, 1));
        cyc(1, 1, 1, 0, 0, '0, "R6 fall to lower layer");
        cyc(1, 1, 0, 0, 0, '0, "R7 up hop keeps flag clear");

        // Collision: write port 0 while requesting.
        cyc(1, 0, 0, 1, 0, mk(1, 0, 0, 1, 0), "R2 write not seen same cycle");
        cyc(1, 0, 0, 0, 0, '0, "R2 write seen next cycle");

        // Port present but not minimal is illegal.
        clear_all();
        wr(6, mk(1, 0, 0, 0, 0));
        cyc(1, 0, 0, 0, 0, '0, "R4 non-minimal rejected");
        wr(6, mk(0, 0, 0, 1, 1));
        cyc(1, 1, 0, 0, 0, '0, "R4 absent port rejected");

        // Only an L1 route: an L0 packet may not climb layers.
        wr(7, mk(1, 0, 0, 0, 1));
        cyc(1, 0, 0, 0, 0, '0, "R6 never to higher layer");
        cyc(1, 1, 0, 0, 0, '0, "R5 highest port index");

        // Only up ports in L0 with flag set: no route.
        clear_all();
        wr(2, mk(1, 1, 1, 1, 0));
        cyc(1, 0, 1, 0, 0, '0, "R8 no legal candidate");
        cyc(1, 1, 1, 0, 0, '0, "R7 fallback restarts flag");

        // Random mix of requests and table rewrites.
        for (int i = 0; i < 3000; i++) begin
            bit we = ($urandom_range(0, 3) == 0);
            cyc($urandom_range(0, 1), $urandom_range(0, L - 1), $urandom_range(0, 1),
                we, $urandom_range(0, P - 1), EW'($urandom), "random R3 R5 R6 R7");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule